// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit sits between the decode stage and the data memory port of a load/store core. It receives one multi-register transfer request and breaks it into a series of single-word memory beats. The request carries a base address, a 16-bit register mask, a direction/ordering mode, a flag that asks for base update and a flag that picks load or store. Each beat names one register index and the word address it moves to or from. Beats go out over a valid/ready handshake. After the last beat the unit raises a one-cycle completion strobe, together with the updated base value.

Four modes cover upward and downward growth, with the base address either included in or excluded from the touched range. In every mode the registers go out in ascending index order and the addresses climb by one word per beat. So the lowest register index always meets the lowest address, even when the range lies below the base. The usual stack disciplines are aliases of these modes:

| Stack discipline | Push | Pop |
|---|---|---|
| Full-descending | 11 | 00 |
| Empty-ascending | 00 | 11 |
| Full-ascending | 01 | 10 |
| Empty-descending | 10 | 01 |

Top module: `blk_xfer_seq`

## Requirements
- R1: While reset is held and after it is released, req_ready is 1 and mem_valid, done and wb_en are 0.
- R2: For N selected registers and base B (B with bits [1:0] cleared), the first beat address depends on req_mode:
  - mode 00: B
  - mode 01: B+4
  - mode 10: B-4N+4
  - mode 11: B-4N
- R3: Each accepted beat raises the next beat's address by 4, so the last beat address is the first address plus 4N-4. mem_valid is 1 exactly while beats remain.
- R4: mem_reg carries the register index, meaning the bit position in req_list. Indices are issued in ascending order, one per accepted beat (mem_valid and mem_ready both 1), so the lowest index pairs with the lowest address.
- R5: While mem_valid is 1 and mem_ready is 0, mem_addr, mem_reg and mem_valid hold their values.
- R6: In the completion cycle, with req_wb set and N>0, wb_en is 1 and wb_value is B+4N for modes 00/01 and B-4N for modes 10/11.
- R7: With req_wb clear, wb_en stays 0 for the whole transfer.
- R8: An empty register list produces no beat. done rises in the cycle after acceptance with wb_en 0 and wb_value equal to B.
- R9: Bits [1:0] of mem_addr are always 0, whatever the low bits of req_base.
- R10: mem_write is the inverse of req_load as sampled at acceptance, and it is constant over all beats of a transfer.
- R11: A request is taken only when req_ready is 1. req_ready is 0 from acceptance until after the single done cycle, which follows the final beat's handshake by one cycle. Requests presented while busy are ignored.
- R12: A push in one mode followed by a pop in its stack partner mode, using the same list and the written-back base, restores the original base. The pairings are listed in the table above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_base | input | 32 | Base address |
| req_list | input | 16 | Register selection mask, bit i = register i |
| req_mode | input | 2 | 00 up-after, 01 up-before, 10 down-after, 11 down-before |
| req_wb | input | 1 | Request base update |
| req_load | input | 1 | 1 = load, 0 = store |
| mem_valid | output | 1 | Beat present |
| mem_ready | input | 1 | Memory accepts beat |
| mem_addr | output | 32 | Word address of the beat |
| mem_reg | output | 4 | Register index of the beat |
| mem_write | output | 1 | Beat is a store |
| done | output | 1 | One-cycle completion strobe |
| wb_en | output | 1 | Write wb_value to the base register |
| wb_value | output | 32 | Updated base value |

## Verification
A corrupted pending mask or index picker shows up within the same beat, as a wrong mem_reg or as a beat that is skipped or repeated. It then misplaces every later address. A wrong start or step in the address register is visible on mem_addr at the first beat, one cycle after acceptance. A wrong write-back value or a stuck state only appears at the done cycle, N+1 cycles after acceptance with a ready memory, or later if the memory stalls. The reference model is compared every cycle and replays push/pop pairs, so a mode decode error shows both as a bad address and as a failed return to the original base.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  // Ordering/direction of a block transfer. bit1 = downward, bit0 = exclude base.
  typedef enum logic [1:0] {
    MODE_UP_AFTER   = 2'b00,
    MODE_UP_BEFORE  = 2'b01,
    MODE_DN_AFTER   = 2'b10,
    MODE_DN_BEFORE  = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } xfer_state_e;

  localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/xfer_plan.sv
module xfer_plan
  import blk_xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int NR = 16,
  parameter int CW = $clog2(NR + 1)
) (
  input  logic [AW-1:0] base,
  input  logic [NR-1:0] list,
  input  xfer_mode_e    mode,
  output logic [CW-1:0] count,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] final_addr
);

  function automatic logic [CW-1:0] tally(input logic [NR-1:0] v);
    logic [CW-1:0] s;
    s = '0;
    for (int i = 0; i < NR; i++) s = s + CW'(v[i]);
    return s;
  endfunction

  function automatic logic [AW-1:0] span_of(input logic [CW-1:0] n);
    return AW'(n) << WORD_SHIFT;
  endfunction

  function automatic logic [AW-1:0] lowest_addr(input logic [AW-1:0] b,
                                                input xfer_mode_e m,
                                                input logic [AW-1:0] span);
    logic [AW-1:0] word;
    word = AW'(1) << WORD_SHIFT;
    case (m)
      MODE_UP_AFTER:  return b;
      MODE_UP_BEFORE: return b + word;
      MODE_DN_AFTER:  return b - span + word;
      default:        return b - span;
    endcase
  endfunction

  function automatic logic [AW-1:0] moved_base(input logic [AW-1:0] b,
                                               input xfer_mode_e m,
                                               input logic [AW-1:0] span);
    return m[1] ? (b - span) : (b + span);
  endfunction

  logic [AW-1:0] base_al;
  logic [AW-1:0] span;

  always_comb begin
    base_al    = {base[AW-1:WORD_SHIFT], {WORD_SHIFT{1'b0}}};
    count      = tally(list);
    span       = span_of(count);
    first_addr = lowest_addr(base_al, mode, span);
    final_addr = moved_base(base_al, mode, span);
  end

endmodule

// File: rtl/xfer_pick.sv
module xfer_pick #(
  parameter int NR = 16,
  parameter int IW = $clog2(NR)
) (
  input  logic [NR-1:0] pend,
  output logic [IW-1:0] idx,
  output logic          any,
  output logic          last
);

  always_comb begin
    idx = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
    any  = |pend;
    last = any && ((pend & (pend - NR'(1))) == '0);
  end

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int NR = 16,
  parameter int IW = $clog2(NR),
  parameter int CW = $clog2(NR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_base,
  input  logic [NR-1:0] req_list,
  input  logic [1:0]    req_mode,
  input  logic          req_wb,
  input  logic          req_load,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [IW-1:0] mem_reg,
  output logic          mem_write,
  output logic          done,
  output logic          wb_en,
  output logic [AW-1:0] wb_value
);

  localparam logic [AW-1:0] STEP = AW'(1) << WORD_SHIFT;

  xfer_state_e   st_q;
  logic [NR-1:0] pend_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] wbv_q;
  logic          wben_q;
  logic          write_q;

  logic [CW-1:0] plan_count;
  logic [AW-1:0] plan_first;
  logic [AW-1:0] plan_final;
  logic [IW-1:0] pick_idx;
  logic          pick_any;
  logic          pick_last;

  // named events for the checks
  logic start_fire;
  logic beat_fire;
  logic beat_last;
  logic list_empty;

  xfer_plan #(.AW(AW), .NR(NR), .CW(CW)) u_plan (
    .base       (req_base),
    .list       (req_list),
    .mode       (xfer_mode_e'(req_mode)),
    .count      (plan_count),
    .first_addr (plan_first),
    .final_addr (plan_final)
  );

  xfer_pick #(.NR(NR), .IW(IW)) u_pick (
    .pend (pend_q),
    .idx  (pick_idx),
    .any  (pick_any),
    .last (pick_last)
  );

  assign req_ready  = (st_q == ST_IDLE);
  assign start_fire = req_valid && req_ready;
  assign list_empty = (plan_count == '0);
  assign mem_valid  = (st_q == ST_RUN);
  assign beat_fire  = mem_valid && mem_ready;
  assign beat_last  = beat_fire && pick_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      wbv_q   <= '0;
      wben_q  <= 1'b0;
      write_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_fire) begin
            pend_q  <= req_list;
            addr_q  <= plan_first;
            wbv_q   <= plan_final;
            wben_q  <= req_wb && !list_empty;
            write_q <= !req_load;
            st_q    <= list_empty ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (beat_fire) begin
            pend_q <= pend_q & ~(NR'(1) << pick_idx);
            addr_q <= addr_q + STEP;
            if (pick_last || !pick_any) st_q <= ST_FIN;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr  = {addr_q[AW-1:WORD_SHIFT], {WORD_SHIFT{1'b0}}};
  assign mem_reg   = pick_idx;
  assign mem_write = write_q;
  assign done      = (st_q == ST_FIN);
  assign wb_en     = done && wben_q;
  assign wb_value  = wbv_q;

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_reg));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last |=> mem_valid && (mem_addr == $past(mem_addr) + STEP));

  // R4
  reg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last |=> mem_reg > $past(mem_reg));

  // R9
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[WORD_SHIFT-1:0] == '0);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  // R11
  last_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> done && !mem_valid);

  // R8
  empty_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire && (req_list == '0) |=> done && !wb_en);

  // R6
  wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  // R10
  write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last |=> $stable(mem_write));

endmodule

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_base = '0;
  logic [15:0] req_list = '0;
  logic [1:0]  req_mode = '0;
  logic        req_wb = 1'b0;
  logic        req_load = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [3:0]  mem_reg;
  logic        mem_write;
  logic        done;
  logic        wb_en;
  logic [31:0] wb_value;

  always #4 clk = ~clk;

  blk_xfer_seq i_blk_xfer_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_list(req_list), .req_mode(req_mode),
    .req_wb(req_wb), .req_load(req_load), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_reg(mem_reg),
    .mem_write(mem_write), .done(done), .wb_en(wb_en), .wb_value(wb_value)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_st = 0;      // 0 idle, 1 beats, 2 completion
  logic [31:0] qa[$];
  int          qr[$];
  logic [31:0] m_wbv = '0;
  bit          m_wben = 0, m_wr = 0, m_empty = 0, m_first = 0, m_stall = 0;
  int          n_sel;
  logic [31:0] b_al, lo;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; qa.delete(); qr.delete(); m_wben = 0;
    end else begin
      case (m_st)
        0: if (req_valid) begin
          b_al  = req_base & ~32'h3;
          n_sel = 0;
          for (int i = 0; i < 16; i++) if (req_list[i]) n_sel++;
          case (req_mode)
            2'd0: lo = b_al;
            2'd1: lo = b_al + 4;
            2'd2: lo = b_al - 4 * n_sel + 4;
            default: lo = b_al - 4 * n_sel;
          endcase
          for (int i = 0; i < 16; i++) if (req_list[i]) begin
            qa.push_back(lo);
            qr.push_back(i);
            lo = lo + 4;
          end
          m_wbv   = req_mode[1] ? b_al - 4 * n_sel : b_al + 4 * n_sel;
          m_wben  = req_wb && (n_sel > 0);
          m_wr    = !req_load;
          m_empty = (n_sel == 0);
          m_first = 1;
          m_stall = 0;
          m_st    = (n_sel > 0) ? 1 : 2;
        end
        1: begin
          m_stall = !mem_ready;
          if (mem_ready) begin
            void'(qa.pop_front());
            void'(qr.pop_front());
            m_first = 0;
            if (qa.size() == 0) m_st = 2;
          end
        end
        default: m_st = 0;
      endcase
    end
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL R11 watchdog actual=hung expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R11 req_ready", {31'b0, req_ready}, {31'b0, m_st == 0});
      check("R3 mem_valid", {31'b0, mem_valid}, {31'b0, m_st == 1});
      check("R11 done", {31'b0, done}, {31'b0, m_st == 2});
      if (m_st == 1) begin
        check(m_stall ? "R5 held addr" : (m_first ? "R2 first addr" : "R3 next addr"),
              mem_addr, qa[0]);
        check(m_stall ? "R5 held reg" : "R4 reg index", {28'b0, mem_reg}, qr[0]);
        check("R10 mem_write", {31'b0, mem_write}, {31'b0, m_wr});
        check("R9 addr low bits", {30'b0, mem_addr[1:0]}, 32'h0);
      end
      if (m_st == 2) begin
        check(m_empty ? "R8 wb_en" : (m_wben ? "R6 wb_en" : "R7 wb_en"),
              {31'b0, wb_en}, {31'b0, m_wben});
        if (m_wben || m_empty)
          check(m_empty ? "R8 wb_value" : "R6 wb_value", wb_value, m_wbv);
      end
    end
  end

  logic [15:0] lfsr = 16'hACE1;

  task automatic run_req(input logic [31:0] b, input logic [15:0] l, input logic [1:0] md,
                         input bit w, input bit ld, input int rp, input bit pester,
                         output logic [31:0] wbo);
    @(negedge clk);
    req_base = b; req_list = l; req_mode = md; req_wb = w; req_load = ld;
    req_valid = 1'b1; mem_ready = 1'b0;
    @(negedge clk);
    if (pester) begin
      req_base = ~b; req_list = ~l; req_mode = ~md; req_load = ~ld;
    end else req_valid = 1'b0;
    wbo = '0;
    for (int k = 0; k < 400; k++) begin
      if (done) begin
        wbo = wb_value;
        req_valid = 1'b0;
        break;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rp)
        0: mem_ready = 1'b1;
        1: mem_ready = k[0];
        2: mem_ready = lfsr[0];
        default: mem_ready = (k % 3 == 2);
      endcase
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  logic [31:0] w1, w2;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req_ready", {31'b0, req_ready}, 32'h1);
    check("R1 mem_valid", {31'b0, mem_valid}, 32'h0);
    check("R1 done", {31'b0, done}, 32'h0);
    check("R1 wb_en", {31'b0, wb_en}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {31'b0, req_ready}, 32'h1);

    for (int md = 0; md < 4; md++) begin
      run_req(32'h0000_0100, 16'h000E, 2'(md), 1, 1, 0, 0, w1);
      run_req(32'h0000_2000, 16'h8421, 2'(md), 0, 0, 1, 0, w1);
      run_req(32'h0000_0103, 16'hFFFF, 2'(md), 1, 0, 2, 1, w1);  // R9 unaligned base, R11 pester
      run_req(32'h0000_0008, 16'h8000, 2'(md), 1, 1, 3, 0, w1);
      run_req(32'h0000_0004, 16'h0000, 2'(md), 1, 0, 0, 1, w1);  // R8 empty list
    end

    // R12 stack round trips: push mode, pop mode
    for (int p = 0; p < 4; p++) begin
      logic [1:0] push_m, pop_m;
      case (p)
        0: begin push_m = 2'b11; pop_m = 2'b00; end
        1: begin push_m = 2'b00; pop_m = 2'b11; end
        2: begin push_m = 2'b01; pop_m = 2'b10; end
        default: begin push_m = 2'b10; pop_m = 2'b01; end
      endcase
      run_req(32'h0000_8000, 16'h40F3, push_m, 1, 0, 2, 0, w1);
      run_req(w1, 16'h40F3, pop_m, 1, 1, 1, 0, w2);
      check("R12 restored base", w2, 32'h0000_8000);
    end

    for (int t = 0; t < 40; t++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_req({lfsr, lfsr ^ 16'h5A5A}, lfsr ^ 16'h3C3C, lfsr[1:0], lfsr[2], lfsr[3],
              t % 4, lfsr[4], w1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule